// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a multi-cycle 16-bit load/store processor. It holds a 6-bit state number in a register. It reads that state's microinstruction from a constant control store and drives the microinstruction's datapath field as the control word for the cycle.

In the same cycle, a small next-address unit forms the following state from three things: the microinstruction's sequencing fields, the upper opcode bits of the instruction register, and two status bits from the rest of the machine. The status bits are the branch-condition result and the memory-ready flag. The datapath therefore runs on the current control word while the sequencer picks the next one. Because the choice depends only on the registered state and on inputs that settle early, it stays off the datapath's critical path.

Every instruction starts with a fetch sequence. A memory-read state repeats until memory signals ready, the instruction register is then loaded, and a decode state follows. The decode state jumps straight to the first execute state of the opcode. Each execute sequence ends by going back to one of the two fetch entry states.

Top module: `useq_ctrl_seq`

## Requirements
- R1: While reset is asserted, and until its release has passed the two-stage synchronizer, the state is 18 and the control word is all zero. After that, the state-18 word is driven for one cycle before the first transition.
- R2: Fetch entry states 18 and 19 both go to state 33. State 35 goes to decode state 32.
- R3: State 33 repeats while memory-ready is low. With memory-ready high it moves to state 35 on the next edge.
- R4: In state 32 the next state is the zero-extended opcode taken from bits [4:1] of the 5-bit opcode input (instruction bits 15..12).
- R5: In branch state 0 the next state is 22 when the branch-condition input is 1 and 18 when it is 0. State 22 goes to 18.
- R6: In subroutine-call state 4 the next state is 21 when bit 0 of the opcode input (instruction bit 11) is 1 and 20 when it is 0. Both 20 and 21 go to 18.
- R7: The memory-wait states 16, 17, 25, 28 and 29 each repeat while memory-ready is low. With memory-ready high they go to 18, 19, 27, 30 and 31 respectively.
- R8: Every execute sequence ends in a fetch entry state. The return-from-interrupt state 8 and the byte-store wait state 17 end in 19; all others end in 18.
- R9: Opcode values 10 and 11 lead to states 10 and 11, which are unused entries that go back to state 18.
- R10: The control word is 14 bits. Bit 0 loads the address register, bit 1 the memory-data register, bit 2 the instruction register, bit 3 the branch flag, bit 4 the register file, bit 5 the condition codes and bit 6 the PC. Bit 7 enables memory, bit 8 selects a write and bit 9 selects a byte access. Bits [11:10] choose the PC source and bits [13:12] the ALU operation. The words are: state 18 0x041, state 33 0x082, state 35 0x004, state 32 0x008, state 16 0x180.
- R11: Inputs not named by the current state's condition are ignored. Memory-ready and branch-condition have no effect in states 35 and 32, and the opcode has no effect outside states 32 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ir_op_i | input | 5 | Instruction bits 15..11 |
| br_en_i | input | 1 | Branch condition result from the datapath |
| mem_rdy_i | input | 1 | Memory access completes this cycle |
| state_o | output | 6 | Current state number |
| ctrl_o | output | 14 | Control word for the datapath |

## Verification
The assertions assume that the opcode, branch-condition and memory-ready inputs are settled before each rising edge and are meaningful in the cycle where a condition samples them. They also assume that memory-ready is a level held through the completing cycle. The bench changes every input only on the falling edge and samples outputs there too, so each value is stable across the rising edge that consumes it. Memory-ready is held low for several cycles before it is raised, which exercises the repeat path of each wait state as well as its exit.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int unsigned ST_W   = 6;
  localparam int unsigned NUM_ST = 1 << ST_W;
  localparam int unsigned OP_W   = 5;
  localparam int unsigned CW_W   = 14;

  // bit of the next-address field that each condition may set
  localparam int unsigned MODE_BIT = 0;
  localparam int unsigned RDY_BIT  = 1;
  localparam int unsigned BR_BIT   = 2;

  localparam logic [ST_W-1:0] ST_FETCH  = 6'd18;
  localparam logic [ST_W-1:0] ST_FETCH2 = 6'd19;
  localparam logic [ST_W-1:0] ST_DECODE = 6'd32;
  localparam logic [ST_W-1:0] ST_MEMRD  = 6'd33;
  localparam logic [ST_W-1:0] ST_IRLD   = 6'd35;

  typedef enum logic [1:0] {
    CND_NONE   = 2'd0,
    CND_READY  = 2'd1,
    CND_BRANCH = 2'd2,
    CND_MODE   = 2'd3
  } cond_e;

  typedef struct packed {
    logic [ST_W-1:0] nxt;
    cond_e           cond;
    logic            disp;
    logic [CW_W-1:0] ctl;
  } uinst_t;

  function automatic uinst_t mk(input logic [ST_W-1:0] n, input cond_e c,
                                input logic d, input logic [CW_W-1:0] w);
    uinst_t u;
    u.nxt  = n;
    u.cond = c;
    u.disp = d;
    u.ctl  = w;
    return u;
  endfunction

  // control word bits: 0 mar, 1 mdr, 2 ir, 3 brflag, 4 reg, 5 cc, 6 pc,
  // 7 mem en, 8 write, 9 byte, [11:10] pc source, [13:12] alu op
  function automatic uinst_t ucode(input int unsigned s);
    uinst_t u;
    case (s)
      18, 19: u = mk(6'd33, CND_NONE,   1'b0, 14'h0041);
      33:     u = mk(6'd33, CND_READY,  1'b0, 14'h0082);
      35:     u = mk(6'd32, CND_NONE,   1'b0, 14'h0004);
      32:     u = mk(6'd0,  CND_NONE,   1'b1, 14'h0008);
      0:      u = mk(6'd18, CND_BRANCH, 1'b0, 14'h0000);
      22:     u = mk(6'd18, CND_NONE,   1'b0, 14'h0840);
      1:      u = mk(6'd18, CND_NONE,   1'b0, 14'h0030);
      5:      u = mk(6'd18, CND_NONE,   1'b0, 14'h1030);
      9:      u = mk(6'd18, CND_NONE,   1'b0, 14'h2030);
      13:     u = mk(6'd18, CND_NONE,   1'b0, 14'h3030);
      14:     u = mk(6'd18, CND_NONE,   1'b0, 14'h0030);
      12:     u = mk(6'd18, CND_NONE,   1'b0, 14'h0440);
      4:      u = mk(6'd20, CND_MODE,   1'b0, 14'h0000);
      20:     u = mk(6'd18, CND_NONE,   1'b0, 14'h0450);
      21:     u = mk(6'd18, CND_NONE,   1'b0, 14'h0850);
      15:     u = mk(6'd28, CND_NONE,   1'b0, 14'h0001);
      28:     u = mk(6'd28, CND_READY,  1'b0, 14'h0092);
      30:     u = mk(6'd18, CND_NONE,   1'b0, 14'h0440);
      2:      u = mk(6'd29, CND_NONE,   1'b0, 14'h0001);
      29:     u = mk(6'd29, CND_READY,  1'b0, 14'h0282);
      31:     u = mk(6'd18, CND_NONE,   1'b0, 14'h0230);
      6:      u = mk(6'd25, CND_NONE,   1'b0, 14'h0001);
      25:     u = mk(6'd25, CND_READY,  1'b0, 14'h0082);
      27:     u = mk(6'd18, CND_NONE,   1'b0, 14'h0030);
      7:      u = mk(6'd23, CND_NONE,   1'b0, 14'h0001);
      23:     u = mk(6'd16, CND_NONE,   1'b0, 14'h0002);
      16:     u = mk(6'd16, CND_READY,  1'b0, 14'h0180);
      3:      u = mk(6'd24, CND_NONE,   1'b0, 14'h0001);
      24:     u = mk(6'd17, CND_NONE,   1'b0, 14'h0202);
      17:     u = mk(6'd17, CND_READY,  1'b0, 14'h0380);
      8:      u = mk(6'd19, CND_NONE,   1'b0, 14'h0440);
      default: u = mk(ST_FETCH, CND_NONE, 1'b0, '0);
    endcase
    return u;
  endfunction

endpackage

// File: rtl/useq_rst_sync.sv
module useq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];

  initial begin
    assert (STAGES >= 2) else $error("synchronizer needs two stages");
  end
endmodule

// File: rtl/useq_ctrl_store.sv
module useq_ctrl_store
  import useq_pkg::*;
#(
  parameter int unsigned DEPTH = NUM_ST
) (
  input  logic [ST_W-1:0] addr_i,
  output uinst_t          word_o
);
  uinst_t rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = ucode(g);
  end

  assign word_o = rom[addr_i];
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
(
  input  logic [ST_W-1:0] nxt_fld_i,
  input  cond_e           cond_i,
  input  logic            disp_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            br_en_i,
  input  logic            mem_rdy_i,
  output logic [ST_W-1:0] nxt_o
);
  logic [ST_W-1:0] mod_bits;

  always_comb begin
    mod_bits = '0;
    case (cond_i)
      CND_READY:  mod_bits[RDY_BIT]  = mem_rdy_i;
      CND_BRANCH: mod_bits[BR_BIT]   = br_en_i;
      CND_MODE:   mod_bits[MODE_BIT] = op_i[0];
      default:    mod_bits = '0;
    endcase
  end

  always_comb begin
    if (disp_i) nxt_o = ST_W'(op_i[OP_W-1:1]);
    else        nxt_o = nxt_fld_i | mod_bits;
  end
endmodule

// File: rtl/useq_ctrl_seq.sv
module useq_ctrl_seq
  import useq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] ir_op_i,
  input  logic            br_en_i,
  input  logic            mem_rdy_i,
  output logic [ST_W-1:0] state_o,
  output logic [CW_W-1:0] ctrl_o
);
  logic            rst_sync_n;
  logic [ST_W-1:0] state_q;
  logic [ST_W-1:0] state_d;
  uinst_t          uword;

  useq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  useq_ctrl_store #(.DEPTH(NUM_ST)) u_store (
    .addr_i(state_q),
    .word_o(uword)
  );

  useq_next_addr u_next (
    .nxt_fld_i(uword.nxt),
    .cond_i   (uword.cond),
    .disp_i   (uword.disp),
    .op_i     (ir_op_i),
    .br_en_i  (br_en_i),
    .mem_rdy_i(mem_rdy_i),
    .nxt_o    (state_d)
  );

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_FETCH;
    else             state_q <= state_d;
  end

  assign state_o = state_q;
  assign ctrl_o  = rst_sync_n ? uword.ctl : '0;

  // R1: the first cycle after synchronized release sits in fetch
  p_release_fetch_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_sync_n) |-> state_q == ST_FETCH);

  // R2
  p_irld_decode_r2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    state_q == ST_IRLD |=> state_q == ST_DECODE);

  // R3
  p_rd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (state_q == ST_MEMRD && !mem_rdy_i) |=> state_q == ST_MEMRD);
  p_rd_done_r3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (state_q == ST_MEMRD && mem_rdy_i) |=> state_q == ST_IRLD);

  // R4
  p_dispatch_r4: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    state_q == ST_DECODE |=> state_q == ST_W'($past(ir_op_i[OP_W-1:1])));

  // R5
  p_branch_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    state_q == 6'd0 |=> state_q == ($past(br_en_i) ? 6'd22 : ST_FETCH));

  // R6
  p_call_mode_r6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    state_q == 6'd4 |=> state_q == ($past(ir_op_i[0]) ? 6'd21 : 6'd20));

  // R8
  p_rti_end_r8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    state_q == 6'd8 |=> state_q == ST_FETCH2);

  // R9
  p_unused_r9: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (state_q == 6'd10 || state_q == 6'd11) |=> state_q == ST_FETCH);

  // R10
  p_fetch_word_r10: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    state_q == ST_FETCH |-> (ctrl_o[0] && ctrl_o[6] && !ctrl_o[7]));
endmodule

// File: tb/useq_ctrl_seq_tb_top.sv
module useq_ctrl_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [4:0]  ir_op;
  logic        br_en;
  logic        mem_rdy;
  logic [5:0]  state;
  logic [13:0] ctrl;
  int          n_chk = 0;
  int          n_err = 0;

  always #4 clk = ~clk;

  useq_ctrl_seq dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .ir_op_i  (ir_op),
    .br_en_i  (br_en),
    .mem_rdy_i(mem_rdy),
    .state_o  (state),
    .ctrl_o   (ctrl)
  );

  task automatic chk_st(input string req, input logic [5:0] exp);
    n_chk++;
    if (state !== exp) begin
      n_err++;
      $display("FAIL %s: state actual %0d expected %0d", req, state, exp);
    end
  endtask

  task automatic chk_cw(input string req, input logic [13:0] exp);
    n_chk++;
    if (ctrl !== exp) begin
      n_err++;
      $display("FAIL %s: control word actual 0x%h expected 0x%h", req, ctrl, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // from a fetch entry state up to the first execute state of op
  task automatic go_fetch(input logic [4:0] op);
    mem_rdy = 1'b0; br_en = 1'b0;
    step(); chk_st("R2", 6'd33); chk_cw("R10", 14'h082);
    step(); chk_st("R3", 6'd33);
    step(); chk_st("R3", 6'd33);
    mem_rdy = 1'b1;
    step(); chk_st("R3", 6'd35); chk_cw("R10", 14'h004);
    br_en = 1'b1;                       // R11: both ignored here
    step(); chk_st("R11", 6'd32); chk_cw("R10", 14'h008);
    ir_op = op;                         // R11: br_en/mem_rdy still high, ignored
    step(); chk_st("R4", {2'b00, op[4:1]});
    mem_rdy = 1'b0; br_en = 1'b0;
  endtask

  task automatic wait_mem(input string req, input logic [5:0] st,
                          input int n, input logic [5:0] done);
    mem_rdy = 1'b0;
    for (int i = 0; i < n; i++) begin
      step(); chk_st(req, st);
    end
    mem_rdy = 1'b1;
    step(); chk_st(req, done);
    mem_rdy = 1'b0;
  endtask

  task automatic t_reset();
    chk_st("R1", 6'd18); chk_cw("R1", 14'h000);
    rst_ni = 1'b1;
    step(); chk_st("R1", 6'd18); chk_cw("R1", 14'h000);
    step(); chk_st("R1", 6'd18); chk_cw("R10", 14'h041);
  endtask

  task automatic t_alu();
    int ops[6] = '{1, 5, 9, 12, 13, 14};
    foreach (ops[k]) begin
      go_fetch({ops[k][3:0], 1'b0});
      ir_op = 5'b11111; mem_rdy = 1'b1; br_en = 1'b1;   // R11: ignored
      step(); chk_st("R8", 6'd18);
      mem_rdy = 1'b0; br_en = 1'b0;
    end
  endtask

  task automatic t_branch();
    go_fetch(5'b00000);
    br_en = 1'b1;
    step(); chk_st("R5", 6'd22);
    br_en = 1'b0;
    step(); chk_st("R5", 6'd18);
    go_fetch(5'b00000);
    br_en = 1'b0; mem_rdy = 1'b1;
    step(); chk_st("R5", 6'd18);
    mem_rdy = 1'b0;
  endtask

  task automatic t_call();
    go_fetch({4'd4, 1'b1});
    step(); chk_st("R6", 6'd21);
    step(); chk_st("R6", 6'd18);
    go_fetch({4'd4, 1'b0});
    step(); chk_st("R6", 6'd20);
    step(); chk_st("R6", 6'd18);
  endtask

  task automatic t_loads();
    go_fetch({4'd6, 1'b0});
    step(); chk_st("R7", 6'd25);
    wait_mem("R7", 6'd25, 3, 6'd27);
    step(); chk_st("R8", 6'd18);
    go_fetch({4'd2, 1'b0});
    step(); chk_st("R7", 6'd29);
    wait_mem("R7", 6'd29, 1, 6'd31);
    step(); chk_st("R8", 6'd18);
  endtask

  task automatic t_stores();
    go_fetch({4'd7, 1'b0});
    step(); chk_st("R7", 6'd23);
    step(); chk_st("R7", 6'd16); chk_cw("R10", 14'h180);
    wait_mem("R7", 6'd16, 2, 6'd18);
    go_fetch({4'd3, 1'b0});
    step(); chk_st("R7", 6'd24);
    step(); chk_st("R7", 6'd17);
    wait_mem("R8", 6'd17, 2, 6'd19);
    step(); chk_st("R2", 6'd33);       // entry 19 also fetches
    mem_rdy = 1'b1;
    step(); chk_st("R2", 6'd35);
    step(); chk_st("R2", 6'd32);
    ir_op = {4'd1, 1'b0};
    step(); chk_st("R4", 6'd1);
    mem_rdy = 1'b0;
    step(); chk_st("R8", 6'd18);
  endtask

  task automatic t_trap_rti();
    go_fetch({4'd15, 1'b0});
    step(); chk_st("R7", 6'd28);
    wait_mem("R7", 6'd28, 2, 6'd30);
    step(); chk_st("R8", 6'd18);
    go_fetch({4'd8, 1'b0});
    step(); chk_st("R8", 6'd19);
  endtask

  task automatic t_unused();
    go_fetch({4'd10, 1'b0});
    step(); chk_st("R9", 6'd18);
    go_fetch({4'd11, 1'b1});
    step(); chk_st("R9", 6'd18);
  endtask

  initial begin
    rst_ni = 1'b0; ir_op = '0; br_en = 1'b0; mem_rdy = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_alu();
    t_branch();
    t_call();
    t_loads();
    t_stores();
    t_trap_rti();
    t_unused();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: R1..run did not end, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule